// File: doc/BRIEF.md
# Watchdog and Clock-Monitor Supervisor

This block guards a small processor core against two failures: software that stops servicing a windowed watchdog, and a system clock that runs too slowly. Both faults drive one shared active-low error pin, modelled as a data value (`errN`) and an output-enable (`errOe`). When neither fault is present the pin is released to high impedance. All durations are counted in instruction cycles, one per `DIV` system clocks.

The watchdog requires a strobe carrying the correct service code in the upper half of a selectable window. A service that comes early, carries a wrong code, or never arrives starts a fixed-length error pulse. The clock monitor compares a slow reference tick, which may be asynchronous, against the instruction-cycle count. If too few instruction cycles fall between two reference ticks, the clock is judged slow. A clock fault stays on the pin through a recovery hold after the clock is back to speed. Both circuits are armed when reset ends, and the clock fault is pending from the start.

An 8-bit configuration write holds three fields. Bits [1:0] select the window, bit [2] enables the clock monitor, and bits [7:3] set the minimum instruction-cycle count per reference period.

Top module: `clk_wd_supervisor`

## Requirements
- R1: One instruction cycle lasts exactly `DIV` (default 10) system clocks. Every window and hold length below is counted in these cycles.
- R2: While `rstN` is low, `errOe` is 0 and `errN` is 1.
- R3: After reset the window select is 2'b11 (longest window) and the clock monitor is enabled with a fault pending. `errOe` is therefore 1 within a few clocks of reset release.
- R4: The window length is 2^(`WIN_BASE_LOG2` + select) instruction cycles; with the default base of 13 that gives 8k, 16k, 32k and 64k. If the window runs out without a service, a watchdog error starts. Any configuration write restarts the window.
- R5: A strobe carrying `SERVICE_KEY` (default 8'h5A) once at least half the window has elapsed restarts the window and raises no error.
- R6: A strobe carrying the correct code before half the window has elapsed raises a watchdog error.
- R7: A strobe carrying any other code raises a watchdog error, whatever the window position.
- R8: A watchdog error holds the pin asserted for `HOLD_IC` (16) instruction cycles, give or take one, and then releases it.
- R9: A reference tick that ends an interval of fewer instruction cycles than the programmed minimum (default 4) raises a clock fault.
- R10: After a reference interval of adequate length, the clock fault stays asserted. A hold of `HOLD_IC` cycles starts at the next adequate tick. The total release delay from the first adequate tick is between 16 and 32 instruction cycles.
- R11: With clock-monitor enable at 0, any pending clock fault is cleared and slow reference intervals are ignored.
- R12: `errN` is 0 exactly when `errOe` is 1. Otherwise `errN` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | Slow reference tick, may be asynchronous |
| svcStrobe | input | 1 | Watchdog service strobe |
| svcCode | input | 8 | Code presented with the service strobe |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgWrData | input | 8 | Configuration: [1:0] window, [2] monitor enable, [7:3] minimum cycles |
| errN | output | 1 | Error pin data, low while an error is active |
| errOe | output | 1 | Error pin output-enable, high while the pin is driven |

## Verification
The watchdog is driven with service strobes placed before and after the half-window point, at all four window sizes, and with both correct and wrong codes. These cases separate the early-service path and the wrong-code path from a valid restart. Unserviced windows at every setting confirm the window length and the division by ten. The reference tick is run at periods of 100 and 30 system clocks, and against a raised threshold. This separates a clock judged fast from one judged slow. It also shows the recovery hold, which starts only at the tick after the first adequate interval.

// File: rtl/supv_pkg.sv
package supv_pkg;

  localparam int CFG_W = 8;
  localparam int MIN_W = 5;

  typedef enum logic [1:0] {
    CM_OK    = 2'd0,
    CM_FAULT = 2'd1,
    CM_AWAIT = 2'd2,
    CM_HOLD  = 2'd3
  } cmState_e;

  typedef struct packed {
    logic winClear;
    logic wdLoad;
    logic cmHoldLoad;
  } ctlStrobe_t;

  typedef struct packed {
    logic icTick;
    logic refEdge;
    logic upperHalf;
    logic winLast;
    logic slowMeas;
    logic wdBusy;
    logic cmBusy;
    logic cmEnable;
  } dpStatus_t;

endpackage

// File: rtl/supv_hold_counter.sv
module supv_hold_counter #(
  parameter int HOLD_IC = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic icTick,
  output logic busy
);

  localparam int HW = $clog2(HOLD_IC + 1);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (load)                  cnt <= HW'(HOLD_IC);
    else if (icTick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R8 / R10: a hold never exceeds its programmed length
  assert_hold_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= HW'(HOLD_IC));

  // R10: a load always makes the hold visible on the next cycle
  assert_hold_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    load |=> busy);

endmodule

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int DIV           = 10,
  parameter int WIN_BASE_LOG2 = 13,
  parameter int HOLD_IC       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        stat
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int WIN_W = WIN_BASE_LOG2 + 3;
  localparam logic [WIN_W:0] WIN_ONE = (WIN_W + 1)'(1) << WIN_BASE_LOG2;
  localparam logic [MIN_W-1:0] MIN_DEFAULT = MIN_W'(4);

  // instruction-cycle prescaler
  logic [DIV_W-1:0] divCnt;
  logic             icTick;

  assign icTick = (divCnt == DIV_W'(DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       divCnt <= '0;
    else if (icTick) divCnt <= '0;
    else             divCnt <= divCnt + 1'b1;
  end

  // configuration register
  logic [1:0]       cfgSel;
  logic             cfgCmEn;
  logic [MIN_W-1:0] cfgMin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSel  <= 2'b11;
      cfgCmEn <= 1'b1;
      cfgMin  <= MIN_DEFAULT;
    end else if (cfgWrEn) begin
      cfgSel  <= cfgWrData[1:0];
      cfgCmEn <= cfgWrData[2];
      cfgMin  <= cfgWrData[7:3];
    end
  end

  // reference tick synchronizer and edge detect
  logic [2:0] refSync;
  logic       refEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refSync <= '0;
    else       refSync <= {refSync[1:0], refTick};
  end

  assign refEdge = refSync[1] & ~refSync[2];

  // instruction cycles seen since the last reference edge, saturating
  logic [MIN_W-1:0] periodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              periodCnt <= '0;
    else if (refEdge)                       periodCnt <= '0;
    else if (icTick && periodCnt != '1)     periodCnt <= periodCnt + 1'b1;
  end

  // watchdog window counter
  logic [WIN_W-1:0] winCnt;
  logic [WIN_W:0]   winLen;

  assign winLen = WIN_ONE << cfgSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        winCnt <= '0;
    else if (ctl.winClear || cfgWrEn) winCnt <= '0;
    else if (icTick)                  winCnt <= winCnt + 1'b1;
  end

  // error hold counters, one per fault source
  logic wdBusy;
  logic cmBusy;

  supv_hold_counter #(.HOLD_IC(HOLD_IC)) uWdHold (
    .clk   (clk),
    .rstN  (rstN),
    .load  (ctl.wdLoad),
    .icTick(icTick),
    .busy  (wdBusy)
  );

  supv_hold_counter #(.HOLD_IC(HOLD_IC)) uCmHold (
    .clk   (clk),
    .rstN  (rstN),
    .load  (ctl.cmHoldLoad),
    .icTick(icTick),
    .busy  (cmBusy)
  );

  always_comb begin
    stat.icTick    = icTick;
    stat.refEdge   = refEdge;
    stat.upperHalf = ({1'b0, winCnt} >= (winLen >> 1));
    stat.winLast   = ({1'b0, winCnt} == (winLen - 1'b1));
    stat.slowMeas  = (periodCnt < cfgMin);
    stat.wdBusy    = wdBusy;
    stat.cmBusy    = cmBusy;
    stat.cmEnable  = cfgCmEn;
  end

  // R1: instruction-cycle ticks are never back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rstN)
    icTick |=> !icTick);

  // R4: a configuration write restarts the window
  assert_cfg_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (winCnt == '0));

  // R9: one reference pulse gives exactly one measurement
  assert_ref_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    refEdge |=> !refEdge);

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
#(
  parameter logic [7:0] SERVICE_KEY = 8'h5A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       svcStrobe,
  input  logic [7:0] svcCode,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl,
  output logic       pinOe
);

  // watchdog decisions
  logic codeOk;
  logic goodSvc;
  logic badSvc;
  logic expire;

  assign codeOk  = (svcCode == SERVICE_KEY);
  assign goodSvc = svcStrobe && codeOk && stat.upperHalf;
  assign badSvc  = svcStrobe && !(codeOk && stat.upperHalf);
  assign expire  = stat.icTick && stat.winLast && !goodSvc;

  // clock monitor state machine
  cmState_e cmState;
  cmState_e cmNext;
  logic     holdStart;

  always_comb begin
    cmNext    = cmState;
    holdStart = 1'b0;
    if (!stat.cmEnable) begin
      cmNext = CM_OK;
    end else begin
      unique case (cmState)
        CM_OK: begin
          if (stat.refEdge && stat.slowMeas) cmNext = CM_FAULT;
        end
        CM_FAULT: begin
          if (stat.refEdge && !stat.slowMeas) cmNext = CM_AWAIT;
        end
        CM_AWAIT: begin
          if (stat.refEdge) begin
            if (stat.slowMeas) begin
              cmNext = CM_FAULT;
            end else begin
              cmNext    = CM_HOLD;
              holdStart = 1'b1;
            end
          end
        end
        CM_HOLD: begin
          if (stat.refEdge && stat.slowMeas) cmNext = CM_FAULT;
          else if (!stat.cmBusy)             cmNext = CM_OK;
        end
        default: cmNext = CM_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmState <= CM_FAULT;
    else       cmState <= cmNext;
  end

  always_comb begin
    ctl.winClear   = goodSvc || badSvc || expire;
    ctl.wdLoad     = badSvc || expire;
    ctl.cmHoldLoad = holdStart;
  end

  // registered pin stage, released while in reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinOe <= 1'b0;
    else       pinOe <= stat.wdBusy || (cmState != CM_OK);
  end

  // R4: an unserviced window end starts a watchdog error
  assert_expire_error_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stat.icTick && stat.winLast && !svcStrobe) |=> stat.wdBusy);

  // R6: a correct code in the lower half is rejected
  assert_early_service_R6: assert property (@(posedge clk) disable iff (!rstN)
    (svcStrobe && codeOk && !stat.upperHalf) |=> stat.wdBusy);

  // R7: a wrong code is always rejected
  assert_wrong_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (svcStrobe && !codeOk) |=> stat.wdBusy);

  // R9: a short reference interval faults the monitor
  assert_slow_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stat.cmEnable && stat.refEdge && stat.slowMeas) |=> (cmState == CM_FAULT));

  // R11: a disabled monitor stays quiet
  assert_monitor_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !stat.cmEnable |=> (cmState == CM_OK));

  // R12: the pin is released once both sources are idle
  assert_pin_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!stat.wdBusy && cmState == CM_OK && !ctl.wdLoad) |=> !pinOe);

endmodule

// File: rtl/clk_wd_supervisor.sv
module clk_wd_supervisor
  import supv_pkg::*;
#(
  parameter int         DIV           = 10,
  parameter int         WIN_BASE_LOG2 = 13,
  parameter int         HOLD_IC       = 16,
  parameter logic [7:0] SERVICE_KEY   = 8'h5A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       svcStrobe,
  input  logic [7:0] svcCode,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic       errN,
  output logic       errOe
);

  ctlStrobe_t ctl;
  dpStatus_t  stat;
  logic       pinOe;

  supv_datapath #(
    .DIV          (DIV),
    .WIN_BASE_LOG2(WIN_BASE_LOG2),
    .HOLD_IC      (HOLD_IC)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .refTick  (refTick),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .ctl      (ctl),
    .stat     (stat)
  );

  supv_control #(
    .SERVICE_KEY(SERVICE_KEY)
  ) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .svcStrobe(svcStrobe),
    .svcCode  (svcCode),
    .stat     (stat),
    .ctl      (ctl),
    .pinOe    (pinOe)
  );

  assign errOe = pinOe;
  assign errN  = ~pinOe;

endmodule

// File: tb/tb_clk_wd_supervisor.sv
module tb_clk_wd_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 5;
  localparam logic [7:0] KEY = 8'h5A;

  // service vectors: {window select, wait clocks, code, error expected}
  localparam int NVEC = 8;
  localparam logic [22:0] SVC_VEC [NVEC] = '{
    {2'd0, 12'd50,   8'h5A, 1'b1},
    {2'd0, 12'd250,  8'h5A, 1'b0},
    {2'd0, 12'd250,  8'h33, 1'b1},
    {2'd1, 12'd200,  8'h5A, 1'b1},
    {2'd1, 12'd400,  8'h5A, 1'b0},
    {2'd2, 12'd700,  8'h5A, 1'b0},
    {2'd2, 12'd500,  8'hA5, 1'b1},
    {2'd3, 12'd1400, 8'h5A, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic       svcStrobe = 1'b0;
  logic [7:0] svcCode = 8'h00;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic       errN;
  logic       errOe;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  clk_wd_supervisor #(
    .DIV(10), .WIN_BASE_LOG2(BASE), .HOLD_IC(16), .SERVICE_KEY(KEY)
  ) dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .svcStrobe(svcStrobe),
    .svcCode(svcCode), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .errN(errN), .errOe(errOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int winClocks(input int sel);
    return (1 << (BASE + sel)) * 10;
  endfunction

  task automatic doReset();
    rstN = 1'b0; refTick = 1'b0; svcStrobe = 1'b0; svcCode = 8'h00;
    cfgWrEn = 1'b0; cfgWrData = 8'h00;
    tick(4);
    check(errOe == 1'b0 && errN == 1'b1, "R2 pin idle during reset", int'(errOe), 0);
    rstN = 1'b1;
  endtask

  task automatic writeCfg(input logic [1:0] sel, input logic cmEn, input logic [4:0] minc);
    cfgWrData = {minc, cmEn, sel};
    cfgWrEn = 1'b1;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] code);
    svcCode = code;
    svcStrobe = 1'b1;
    tick(1);
    svcStrobe = 1'b0;
  endtask

  task automatic refTrain(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      refTick = 1'b1;
      tick(4);
      refTick = 1'b0;
      tick(period - 4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int cnt;
    int lenClk;

    // reset defaults, recovery after reset, default window (R3, R10, R12)
    doReset();
    fork
      refTrain(27, 100);
      begin
        tick(3);
        check(errOe == 1'b1, "R3 clock fault pending after reset", int'(errOe), 1);
        check(errN == 1'b0, "R12 pin driven low with enable", int'(errN), 0);
        tick(244);
        check(errOe == 1'b1, "R10 fault held through first good interval", int'(errOe), 1);
        tick(200);
        check(errOe == 1'b0, "R10 fault released after hold", int'(errOe), 0);
        check(errN == 1'b1, "R12 pin data high when released", int'(errN), 1);
        tick(2093);
        check(errOe == 1'b0, "R3 default window not yet expired", int'(errOe), 0);
        tick(40);
        check(errOe == 1'b1, "R3 default window select 2'b11 expired", int'(errOe), 1);
      end
    join

    // window expiry at each setting (R1, R4, R8, R11)
    for (int sel = 0; sel < 4; sel++) begin
      doReset();
      writeCfg(2'(sel), 1'b0, 5'd4);
      tick(4);
      check(errOe == 1'b0, "R11 disabling the monitor clears its fault", int'(errOe), 0);
      lenClk = winClocks(sel);
      cnt = 4;
      while (!errOe && cnt < 30000) begin
        tick(1);
        cnt++;
      end
      check(cnt >= lenClk - 10 && cnt <= lenClk + 2,
            $sformatf("R4 R1 expiry clocks for select %0d", sel), cnt, lenClk);
      tick(100);
      check(errOe == 1'b1, "R8 watchdog error still held", int'(errOe), 1);
      tick(80);
      check(errOe == 1'b0, "R8 watchdog error released", int'(errOe), 0);
    end

    // service vectors (R5, R6, R7)
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]  vSel;
      logic [11:0] vWait;
      logic [7:0]  vCode;
      logic        vExp;
      {vSel, vWait, vCode, vExp} = SVC_VEC[v];
      doReset();
      writeCfg(vSel, 1'b0, 5'd4);
      tick(4);
      tick(int'(vWait));
      strobe(vCode);
      tick(1);
      check(errOe == vExp,
            $sformatf("R5 R6 R7 service vector %0d", v), int'(errOe), int'(vExp));
      if (!vExp) begin
        tick(winClocks(int'(vSel)) / 2);
        check(errOe == 1'b0, "R5 valid service restarted the window", int'(errOe), 0);
      end
    end

    // slow clock detection and timed release (R9, R10)
    doReset();
    fork
      refTrain(6, 100);
      begin
        tick(590);
        check(errOe == 1'b0, "R10 recovered before slow phase", int'(errOe), 0);
      end
    join
    refTrain(6, 30);
    check(errOe == 1'b1, "R9 short reference interval faults", int'(errOe), 1);
    fork
      refTrain(8, 100);
      begin
        tick(150);
        check(errOe == 1'b1, "R10 fault held after first good interval", int'(errOe), 1);
        cnt = 50;
        while (errOe && cnt < 1000) begin
          tick(1);
          cnt++;
        end
        check(cnt >= 160 && cnt <= 320, "R10 release delay in clocks", cnt, 270);
      end
    join

    // programmable threshold (R9) and disabled monitor ignoring slow ticks (R11)
    writeCfg(2'b11, 1'b1, 5'd12);
    refTrain(3, 100);
    check(errOe == 1'b1, "R9 raised threshold faults a 10-cycle interval", int'(errOe), 1);
    writeCfg(2'b11, 1'b0, 5'd12);
    tick(4);
    check(errOe == 1'b0, "R11 disable clears fault", int'(errOe), 0);
    refTrain(3, 30);
    check(errOe == 1'b0, "R11 slow ticks ignored while disabled", int'(errOe), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule